// File: doc/BRIEF.md
# USB Host Interrupt Register Bank

This block is the interrupt register group of a full-/low-speed USB host controller. Internal controller logic reports seven kinds of event as single-cycle pulses. Each pulse latches a sticky flag in a status register. Software clears a flag by writing a one to its bit. A per-source enable register, together with a global master enable, decides which latched flags drive the single interrupt line to the system interrupt controller.

Enable bits have two addresses. At the set address, writing a one sets the matching bit. At the clear address, writing a one clears the matching bit, and a read there returns the current enables. A write of zero has no effect at either address, so software never needs a read-modify-write. Registers are reached through a plain 32-bit bus with address, write strobe, write data and read data. Read data is combinational from the addressed register, and writes take effect at the clock edge.

Top module: `usbh_irq_bank`

## Requirements
- R1: After reset every status flag, every enable bit and the master enable are 0, the interrupt output is low, and all three register offsets read 0.
- R2: An event pulse on input bit i sets status bit i at the next clock edge, whether or not enable bit i is set. Status bit positions: 6 root-hub change, 5 frame-number overflow, 4 unrecoverable error, 3 resume detected, 2 start of frame, 1 done-head writeback, 0 scheduling overrun.
- R3: Writing to the status offset (0x0) clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R4: If an event pulse and a software clear hit the same flag in one cycle, the flag is set afterwards.
- R5: Writing to the enable-set offset (0x4) sets enable bits 6:0 and the master enable (bit 31) wherever the write data is 1. Zeros leave the bits unchanged. Reading 0x4 returns the enables in the same positions.
- R6: Writing to the enable-clear offset (0x8) clears the enable bits 6:0 and the master enable in bit 31 wherever the write data is 1. Reading 0x8 returns the same value as 0x4.
- R7: Bits 30:7 read 0 at all three offsets, even after all-ones writes.
- R8: The interrupt output is high exactly when the master enable is set and at least one source has both its status flag and its enable bit set.
- R9: Any offset other than 0x0, 0x4 and 0x8 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_pulse | input | 7 | Single-cycle event pulses, bit order as the status register |
| irq | output | 1 | Interrupt request to the system interrupt controller |

## Verification
Events are fired one source at a time with all enables off, which shows the bit order and that latching does not depend on enables. Clears use alternating masks (0x55, then 0x2A) and an all-zero write, which separates write-one-to-clear from a plain register write. Set and clear writes at the two enable addresses use disjoint, overlapping and all-zero patterns, including the master enable alone, which separates the aliasing from independent storage. The interrupt line is checked with a matching flag but the master enable off, with the master enable on but a non-matching flag, and with both matching, and also with an event landing in the same cycle as its own clear, all-ones writes to reserved bits and writes to unused offsets.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned MIE_POS = REG_W - 1;
  localparam int unsigned OWN_POS = REG_W - 2;

  localparam int unsigned OFF_STS    = 'h0;
  localparam int unsigned OFF_EN_SET = 'h4;
  localparam int unsigned OFF_EN_CLR = 'h8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STS    = 2'd1,
    SEL_EN_SET = 2'd2,
    SEL_EN_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/usbh_irq_rst_sync.sv
module usbh_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] sts_d;
  logic         sts_en;

  // A pulse in the same cycle as its own clear keeps the flag set.
  always_comb begin
    sts_en = clr_we_i | (|evt_i);
    sts_d  = (sts_q & ~(clr_we_i ? clr_mask_i : '0)) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((sts_o & $past(evt_i)) == $past(evt_i)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && (|(clr_mask_i & ~evt_i))) |=>
      ((sts_o & $past(clr_mask_i & ~evt_i)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i && (evt_i == '0)) |=> $stable(sts_o));

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && (|(clr_mask_i & evt_i))) |=>
      ((sts_o & $past(clr_mask_i & evt_i)) == $past(clr_mask_i & evt_i)));
endmodule

// File: rtl/usbh_irq_enable.sv
module usbh_irq_enable #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] src_mask_i,
  input  logic         mie_mask_i,
  output logic [N-1:0] en_o,
  output logic         mie_o
);
  logic [N-1:0] en_q, en_d;
  logic         mie_q, mie_d;
  logic         upd;
  logic [N-1:0] set_m, clr_m;

  always_comb begin
    upd   = set_we_i | clr_we_i;
    set_m = set_we_i ? src_mask_i : '0;
    clr_m = clr_we_i ? src_mask_i : '0;
    en_d  = (en_q | set_m) & ~clr_m;
    mie_d = (mie_q | (set_we_i & mie_mask_i)) & ~(clr_we_i & mie_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      mie_q <= 1'b0;
    end else if (upd) begin
      en_q  <= en_d;
      mie_q <= mie_d;
    end
  end

  assign en_o  = en_q;
  assign mie_o = mie_q;

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> (((en_o & $past(src_mask_i)) == $past(src_mask_i)) &&
                  (mie_o || !$past(mie_mask_i))));

  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (((en_o & $past(src_mask_i)) == '0) &&
                  !(mie_o && $past(mie_mask_i))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i) |=> ($stable(en_o) && $stable(mie_o)));
endmodule

// File: rtl/usbh_irq_bank.sv
module usbh_irq_bank
  import usbh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic              irq
);
  logic rst_n_i;
  reg_sel_e sel;
  logic [NUM_SRC-1:0] sts, en;
  logic mie;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[MIE_POS-1:NUM_SRC];

  usbh_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    if (reg_addr == ADDR_W'(OFF_STS))         sel = SEL_STS;
    else if (reg_addr == ADDR_W'(OFF_EN_SET)) sel = SEL_EN_SET;
    else if (reg_addr == ADDR_W'(OFF_EN_CLR)) sel = SEL_EN_CLR;
    else                                      sel = SEL_NONE;
  end

  usbh_irq_status #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n_i), .evt_i(evt_pulse),
    .clr_we_i(reg_wr && (sel == SEL_STS)),
    .clr_mask_i(reg_wdata[NUM_SRC-1:0]),
    .sts_o(sts)
  );

  usbh_irq_enable #(.N(NUM_SRC)) u_enable (
    .clk(clk), .rst_n(rst_n_i),
    .set_we_i(reg_wr && (sel == SEL_EN_SET)),
    .clr_we_i(reg_wr && (sel == SEL_EN_CLR)),
    .src_mask_i(reg_wdata[NUM_SRC-1:0]),
    .mie_mask_i(reg_wdata[MIE_POS]),
    .en_o(en), .mie_o(mie)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STS: reg_rdata[NUM_SRC-1:0] = sts;
      SEL_EN_SET, SEL_EN_CLR: begin
        reg_rdata[NUM_SRC-1:0] = en;
        reg_rdata[MIE_POS]     = mie;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = mie & (|(sts & en));

  p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_rdata[OWN_POS:NUM_SRC] == '0));

  p_irq_mie_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !mie |-> !irq);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (|(sts & en)));

  p_bad_off_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sel == SEL_NONE) |-> (reg_rdata == '0));

  p_alias_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sel == SEL_EN_CLR) |-> (reg_rdata[NUM_SRC-1:0] == en));
endmodule

// File: tb/usbh_irq_bank_bench.sv
module usbh_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_STS = 4'h0, A_SET = 4'h4, A_CLR = 4'h8;

  always #5 clk = ~clk;

  usbh_irq_bank u_usbh_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic clear_all();
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_STS, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(A_STS, d); check("R1 status", d, 32'h0);
    rd(A_SET, d); check("R1 enable", d, 32'h0);
    rd(A_CLR, d); check("R1 enable alias", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_events();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      rd(A_STS, d);
      check("R2 single event", d, 32'(1) << i);
      check("R2 no irq without enable", {31'h0, irq}, 32'h0);
      wr(A_STS, 32'(1) << i);
    end
    pulse(7'h41);
    rd(A_STS, d); check("R2 two events", d, 32'h41);
    wr(A_STS, 32'h7F);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(7'h7F);
    wr(A_STS, 32'h0);
    rd(A_STS, d); check("R3 zero write keeps", d, 32'h7F);
    wr(A_STS, 32'h55);
    rd(A_STS, d); check("R3 clear 0x55", d, 32'h2A);
    wr(A_STS, 32'h2A);
    rd(A_STS, d); check("R3 clear 0x2A", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pulse(7'h03);
    @(negedge clk);
    reg_addr = A_STS; reg_wdata = 32'h03; reg_wr = 1'b1; evt_pulse = 7'h01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    rd(A_STS, d); check("R4 event beats clear", d, 32'h01);
    wr(A_STS, 32'h7F);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_SET, 32'h0000_0011);
    rd(A_SET, d); check("R5 set bits", d, 32'h0000_0011);
    wr(A_SET, 32'h0);
    rd(A_SET, d); check("R5 zero write keeps", d, 32'h0000_0011);
    wr(A_SET, 32'h8000_0022);
    rd(A_SET, d); check("R5 set more and master", d, 32'h8000_0033);
    wr(A_CLR, 32'h0000_0030);
    rd(A_SET, d); check("R6 clear overlap", d, 32'h8000_0003);
    rd(A_CLR, d); check("R6 read alias", d, 32'h8000_0003);
    wr(A_CLR, 32'h0);
    rd(A_CLR, d); check("R6 zero write keeps", d, 32'h8000_0003);
    wr(A_CLR, 32'h8000_0000);
    rd(A_SET, d); check("R6 clear master", d, 32'h0000_0003);
    clear_all();
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_SET, 32'hFFFF_FFFF);
    rd(A_SET, d); check("R7 enable reserved", d, 32'h8000_007F);
    rd(A_CLR, d); check("R7 alias reserved", d, 32'h8000_007F);
    pulse(7'h7F);
    rd(A_STS, d); check("R7 status reserved", d, 32'h0000_007F);
    clear_all();
  endtask

  task automatic t_irq();
    pulse(7'h04);
    wr(A_SET, 32'h0000_0004);
    check("R8 flag+enable, master off", {31'h0, irq}, 32'h0);
    wr(A_SET, 32'h8000_0000);
    check("R8 all set", {31'h0, irq}, 32'h1);
    wr(A_CLR, 32'h0000_0004);
    wr(A_SET, 32'h0000_0008);
    check("R8 enable mismatch", {31'h0, irq}, 32'h0);
    pulse(7'h08);
    check("R8 matching event raises", {31'h0, irq}, 32'h1);
    wr(A_STS, 32'h08);
    check("R8 clear drops", {31'h0, irq}, 32'h0);
    clear_all();
  endtask

  task automatic t_bad_offset();
    logic [31:0] d;
    pulse(7'h10);
    wr(A_SET, 32'h8000_0010);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'hC, d); check("R9 read 0xC", d, 32'h0);
    rd(4'h1, d); check("R9 read 0x1", d, 32'h0);
    rd(A_STS, d); check("R9 status untouched", d, 32'h10);
    rd(A_SET, d); check("R9 enable untouched", d, 32'h8000_0010);
    check("R9 irq still high", {31'h0, irq}, 32'h1);
    clear_all();
  endtask

  initial begin
    t_reset();
    t_events();
    t_w1c();
    t_collision();
    t_enable();
    t_reserved();
    t_irq();
    t_bad_offset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule